// File: doc/BRIEF.md
# Four-Level Backplane Bus Arbiter with Grant Daisy Chain

This block is the system-controller arbiter for a shared parallel backplane. Each slot on the backplane raises an active-low bus request on one of four request levels. The lines pass through a two-flop synchronizer, and the arbiter then picks one level. It drives that level's active-low grant into a per-level daisy chain. Along the chain, each slot either keeps the grant or hands it on to the next slot.

A static mode input selects the policy. Priority mode serves the highest-numbered level. Round-robin mode rotates downward through the levels. Single-level mode answers level 3 alone.

The new owner signals that it has taken the bus by pulling the bus-busy line low. The arbiter then withdraws its grant, and it makes no new grant until bus-busy is released. In priority mode, a request that arrives above the owner's level makes the arbiter pull bus-clear low, which asks the owner to let go of the bus.

Top module: `bus_arbiter_top`

## Requirements
- R1: While reset is high, and at the first sampling point after reset, every grant line `bg_n` is high (inactive) and `bclr_n` is high.
- R2: Starting from an idle bus with no grant pending, a request must be stable before clock edge 1. The grant for its level is still inactive after edge 2 and becomes active after edge 3.
- R3: Priority mode, selected when `mode` is 2'b00 (2'b11 behaves the same way), grants the highest-numbered pending level. Grant line `bg_n[L]` serves level L.
- R4: Round-robin mode (`mode` = 2'b01) checks the levels in the order last-1, last-2, last-3, last. Here "last" is the level granted most recently (0 after reset), and the count wraps from 0 to 3.
- R5: Single-level mode (`mode` = 2'b10) grants only level 3. Requests on levels 0 to 2 produce no grant.
- R6: Within one level, the granted slot is the lowest-index requesting slot, since slot 0 sits nearest the arbiter. A slot that does not request on the granted level passes that grant on to the next slot.
- R7: At most one of the `bg_n` lines is active, and at most one `slot_gnt` bit is set, at any time.
- R8: The grant is held until the synchronized `bbsy_n` goes low. It is then withdrawn on the third clock edge after `bbsy_n` falls. No grant is issued while `bbsy_n` stays low, even if requests are pending.
- R9: `bclr_n` goes low only in priority mode, and only while the bus is held and a pending level is above the owner's level. It returns high on the third clock edge after `bbsy_n` rises. It is never low while a grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 00 priority, 01 round-robin, 10 single-level, 11 priority |
| slot_req_n | input | SLOTS | Active-low request of each slot; slot 0 is nearest the arbiter |
| slot_lvl | input | 2*SLOTS | Request level of each slot, two bits per slot |
| bbsy_n | input | 1 | Active-low bus-busy, pulled by the master that owns the bus |
| bg_n | output | 4 | Active-low grant driven into the head of each level's chain |
| bclr_n | output | 1 | Active-low request for the owner to release the bus |
| slot_gnt | output | SLOTS | Slot that has kept a grant from its chain |

## Verification
While the bus is held, two functions are active in the same cycles: grant suppression and the bus-clear decision. The bench provokes this by taking the bus and loading a fresh set of requests on the same clock. Each time, it then checks that no grant appears while bus-busy stays low. It also checks that `bclr_n` follows a model that compares the highest new level with the owner's level, which is true only in priority mode. Randomized request patterns in every mode are compared against a reference model of the policy and of the chain, and directed cases cover exact latencies and the single-level filter.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LEVELS = 4;
  localparam int LW     = 2;

  typedef enum logic [1:0] {
    MODE_PRIO   = 2'b00,
    MODE_RR     = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_PRIO2  = 2'b11
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_OFFER = 2'b01,
    ST_HELD  = 2'b10
  } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int          W        = 5,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [LEVELS-1:0] pend,
  input  logic [LW-1:0]     last,
  output logic              valid,
  output logic [LW-1:0]     lvl
);
  logic [LW-1:0] idx;

  always_comb begin
    valid = 1'b0;
    lvl   = '0;
    idx   = '0;
    case (arb_mode_e'(mode))
      MODE_RR: begin
        for (int k = 1; k <= LEVELS; k++) begin
          idx = last - LW'(k);
          if (!valid && pend[idx]) begin
            valid = 1'b1;
            lvl   = idx;
          end
        end
      end
      MODE_SINGLE: begin
        valid = pend[LEVELS-1];
        lvl   = LW'(LEVELS-1);
      end
      default: begin
        for (int l = 0; l < LEVELS; l++) begin
          if (pend[l]) begin
            valid = 1'b1;
            lvl   = LW'(l);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/grant_pass_cell.sv
module grant_pass_cell
  import arb_pkg::*;
(
  input  logic [LEVELS-1:0] gin_n,
  input  logic              req_n,
  input  logic [LW-1:0]     lvl,
  output logic [LEVELS-1:0] gout_n,
  output logic              taken
);
  always_comb begin
    taken = 1'b0;
    for (int l = 0; l < LEVELS; l++) begin
      if (!gin_n[l] && !req_n && lvl == LW'(l)) begin
        gout_n[l] = 1'b1;
        taken     = 1'b1;
      end else begin
        gout_n[l] = gin_n[l];
      end
    end
  end
endmodule

// File: rtl/bus_arbiter_top.sv
module bus_arbiter_top
  import arb_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic [SLOTS-1:0]     slot_req_n,
  input  logic [2*SLOTS-1:0]   slot_lvl,
  input  logic                 bbsy_n,
  output logic [LEVELS-1:0]    bg_n,
  output logic                 bclr_n,
  output logic [SLOTS-1:0]     slot_gnt
);
  localparam int SW = LEVELS + 1;

  logic [LEVELS-1:0] req_line_n;
  logic [LEVELS-1:0] req_s_n;
  logic              bbsy_s_n;
  logic [LEVELS-1:0] pend;
  logic              busy;
  logic              sel_valid;
  logic [LW-1:0]     sel_lvl;
  logic              higher;
  logic              prio_mode;

  arb_state_e        state;
  logic [LW-1:0]     owner;
  logic [LW-1:0]     last;
  logic [LEVELS-1:0] bg_q;
  logic              clr_q;

  logic [LEVELS-1:0] chain_n [SLOTS+1];

  // wired-AND of the slot requests onto the four level lines
  always_comb begin
    req_line_n = '1;
    for (int i = 0; i < SLOTS; i++) begin
      for (int l = 0; l < LEVELS; l++) begin
        if (!slot_req_n[i] && slot_lvl[2*i +: 2] == LW'(l)) req_line_n[l] = 1'b0;
      end
    end
  end

  arb_sync #(.W(SW), .RST_VAL({SW{1'b1}})) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bbsy_n, req_line_n}),
    .q   ({bbsy_s_n, req_s_n})
  );

  assign pend      = ~req_s_n;
  assign busy      = ~bbsy_s_n;
  assign prio_mode = (mode == MODE_PRIO) || (mode == MODE_PRIO2);

  arb_select u_sel (
    .mode  (mode),
    .pend  (pend),
    .last  (last),
    .valid (sel_valid),
    .lvl   (sel_lvl)
  );

  always_comb begin
    higher = 1'b0;
    for (int l = 0; l < LEVELS; l++) begin
      if (pend[l] && LW'(l) > owner) higher = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      owner <= '0;
      last  <= '0;
      bg_q  <= '1;
      clr_q <= 1'b0;
    end else begin
      clr_q <= (state == ST_HELD) && busy && prio_mode && (clr_q || higher);
      case (state)
        ST_IDLE: begin
          if (sel_valid && !busy) begin
            bg_q  <= ~(LEVELS'(1) << sel_lvl);
            owner <= sel_lvl;
            last  <= sel_lvl;
            state <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (busy) begin
            bg_q  <= '1;
            state <= ST_HELD;
          end
        end
        ST_HELD: begin
          if (!busy) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bg_n   = bg_q;
  assign bclr_n = ~clr_q;

  assign chain_n[0] = bg_q;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      grant_pass_cell u_cell (
        .gin_n  (chain_n[i]),
        .req_n  (slot_req_n[i]),
        .lvl    (slot_lvl[2*i +: 2]),
        .gout_n (chain_n[i+1]),
        .taken  (slot_gnt[i])
      );
    end
  endgenerate
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              bbsy_n,
  input logic [LEVELS-1:0] bg_n,
  input logic              bclr_n,
  input logic [SLOTS-1:0]  slot_gnt,
  input logic [LEVELS-1:0] tail_n
);
  assert_one_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bg_n));

  assert_one_slot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_gnt));

  // a grant is missing at the chain end exactly when some slot kept it
  assert_chain_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (tail_n != bg_n) == (|slot_gnt));

  assert_new_grant_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (bg_n != '1 && $past(bg_n) == '1) |-> $past(bbsy_n, 3));

  assert_clr_prio_R9: assert property (@(posedge clk) disable iff (rst)
    !bclr_n |-> ($past(mode) == MODE_PRIO || $past(mode) == MODE_PRIO2));

  assert_clr_no_grant_R9: assert property (@(posedge clk) disable iff (rst)
    !bclr_n |-> bg_n == '1);
endmodule

bind bus_arbiter_top arb_checker #(.SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .bbsy_n   (bbsy_n),
  .bg_n     (bg_n),
  .bclr_n   (bclr_n),
  .slot_gnt (slot_gnt),
  .tail_n   (chain_n[SLOTS])
);

// File: tb/sim_bus_arbiter_top.sv
`timescale 1ns/1ps
module sim_bus_arbiter_top;
  localparam int SLOTS = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         mode = 2'b00;
  logic [SLOTS-1:0]   slot_req_n = '1;
  logic [2*SLOTS-1:0] slot_lvl = '0;
  logic               bbsy_n = 1'b1;
  logic [3:0]         bg_n;
  logic               bclr_n;
  logic [SLOTS-1:0]   slot_gnt;

  int n_chk  = 0;
  int n_fail = 0;
  int last_lvl = 0;

  always #2 clk = ~clk;

  bus_arbiter_top #(.SLOTS(SLOTS)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .slot_req_n(slot_req_n),
    .slot_lvl(slot_lvl), .bbsy_n(bbsy_n), .bg_n(bg_n), .bclr_n(bclr_n),
    .slot_gnt(slot_gnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pend_of(input logic [SLOTS-1:0] rq, input logic [2*SLOTS-1:0] lv);
    logic [3:0] p = '0;
    for (int i = 0; i < SLOTS; i++) if (!rq[i]) p[lv[2*i +: 2]] = 1'b1;
    return p;
  endfunction

  function automatic int exp_level(input logic [1:0] m, input logic [3:0] p, input int last);
    int r = -1;
    if (m == 2'b01) begin
      for (int k = 1; k <= 4; k++) begin
        int idx = (last + 4 - k) % 4;
        if (r < 0 && p[idx]) r = idx;
      end
    end else if (m == 2'b10) begin
      r = p[3] ? 3 : -1;
    end else begin
      for (int l = 0; l < 4; l++) if (p[l]) r = l;
    end
    return r;
  endfunction

  function automatic int exp_slot(input int lvl, input logic [SLOTS-1:0] rq, input logic [2*SLOTS-1:0] lv);
    int s = -1;
    for (int i = SLOTS - 1; i >= 0; i--) if (!rq[i] && int'(lv[2*i +: 2]) == lvl) s = i;
    return s;
  endfunction

  function automatic int max_pend(input logic [3:0] p);
    int r = -1;
    for (int l = 0; l < 4; l++) if (p[l]) r = l;
    return r;
  endfunction

  function automatic int grant_level(input logic [3:0] g);
    int r = -1;
    for (int l = 0; l < 4; l++) if (!g[l]) r = l;
    return r;
  endfunction

  task automatic wait_grant(output int lvl);
    lvl = -1;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #1;
      if (bg_n != 4'hF) begin
        lvl = grant_level(bg_n);
        break;
      end
    end
  endtask

  task automatic run_one(input logic [SLOTS-1:0] rq, input logic [2*SLOTS-1:0] lv,
                         input logic [SLOTS-1:0] rq2, input logic [2*SLOTS-1:0] lv2);
    int e, got, es, e2;
    bit prio;
    @(negedge clk);
    slot_req_n = rq; slot_lvl = lv;
    e = exp_level(mode, pend_of(rq, lv), last_lvl);
    wait_grant(got);
    if (mode == 2'b10) check(got == e, "R5 single-level grant", got, e);
    else if (mode == 2'b01) check(got == e, "R4 round-robin grant", got, e);
    else check(got == e, "R3 priority grant", got, e);
    if (e < 0 || got != e) begin
      @(negedge clk); slot_req_n = '1;
      repeat (6) @(posedge clk);
      return;
    end
    last_lvl = e;
    es = exp_slot(e, rq, lv);
    check(slot_gnt == SLOTS'(1 << es), "R6 chain slot", int'(slot_gnt), 1 << es);
    @(negedge clk);
    bbsy_n = 1'b0; slot_req_n = rq2; slot_lvl = lv2;
    repeat (3) @(posedge clk); #1;
    check(bg_n == 4'hF, "R8 grant withdrawn", int'(bg_n), 15);
    repeat (4) @(posedge clk); #1;
    check(bg_n == 4'hF, "R8 no grant while busy", int'(bg_n), 15);
    prio = (mode == 2'b00 || mode == 2'b11);
    e2 = (prio && max_pend(pend_of(rq2, lv2)) > e) ? 0 : 1;
    check(bclr_n == 1'(e2), "R9 clear decision", int'(bclr_n), e2);
    @(negedge clk);
    slot_req_n = '1; bbsy_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check(bclr_n == 1'b1, "R9 clear released", int'(bclr_n), 1);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int got;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk); #1;
    check(bg_n == 4'hF, "R1 grants idle in reset", int'(bg_n), 15);
    check(bclr_n == 1'b1, "R1 clear idle in reset", int'(bclr_n), 1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(bg_n == 4'hF && bclr_n, "R1 after reset", int'(bg_n), 15);

    // R2 exact latency, slot 0 level 2
    @(negedge clk);
    slot_req_n = 4'b1110; slot_lvl = 8'b00_00_00_10;
    repeat (2) @(posedge clk); #1;
    check(bg_n == 4'hF, "R2 not before third edge", int'(bg_n), 15);
    @(posedge clk); #1;
    check(bg_n == 4'b1011, "R2 grant on third edge", int'(bg_n), 11);
    last_lvl = 2;
    // R8 grant held until busy seen
    @(negedge clk); bbsy_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    check(bg_n == 4'b1011, "R8 grant held", int'(bg_n), 11);
    @(posedge clk); #1;
    check(bg_n == 4'hF, "R8 grant dropped", int'(bg_n), 15);
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); #1;
      check(bg_n == 4'hF, "R8 no grant while busy", int'(bg_n), 15);
    end
    @(negedge clk); bbsy_n = 1'b1;
    wait_grant(got);
    check(got == 2, "R8 grant after release", got, 2);
    @(negedge clk); bbsy_n = 1'b0; slot_req_n = '1;
    repeat (4) @(posedge clk);
    @(negedge clk); bbsy_n = 1'b1;
    repeat (5) @(posedge clk);

    // R6 chain: slot0 on level 1 forwards level-2 grant to slot1
    mode = 2'b00;
    run_one(4'b0101, 8'b00_10_10_01, 4'hF, '0);
    // R9 directed: owner level 1, level 3 arrives while busy
    run_one(4'b1110, 8'b00_00_00_01, 4'b1101, 8'b00_00_11_00);
    // R5 single mode ignores levels 0..2, then honours 3
    mode = 2'b10;
    run_one(4'b1000, 8'b00_10_01_00, 4'hF, '0);
    run_one(4'b0000, 8'b11_10_01_00, 4'b1110, 8'b00_00_00_11);
    // R4 round-robin with all four levels pending
    mode = 2'b01;
    for (int r = 0; r < 6; r++) run_one(4'b0000, 8'b11_10_01_00, 4'hF, '0);

    // constrained random over all modes
    for (int it = 0; it < 60; it++) begin
      logic [SLOTS-1:0] rq, rq2;
      logic [2*SLOTS-1:0] lv, lv2;
      @(negedge clk);
      mode = 2'($urandom_range(0, 3));
      rq = SLOTS'($urandom); lv = (2*SLOTS)'($urandom);
      rq2 = SLOTS'($urandom); lv2 = (2*SLOTS)'($urandom);
      run_one(rq, lv, rq2, lv2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule